// File: doc/BRIEF.md
# Scan Transaction Sequencer with Target Clock Pulses

This block is the host side of a bit-serial scan link to a target that holds a chain of shadow registers next to a small processor. From one start strobe it runs a transaction built from up to four phases, each enabled on its own: a pulse on a separate target processor clock, a lone serial-clock pulse with no data, a full scan that shifts a byte vector out on the serial data line while shifting the returned vector in, and a closing phase that pulses the processor clock and then the serial clock once each.

All timing comes from a programmable quarter-period length counted in system clock cycles; every high or low half of either generated clock lasts two quarters. The quarter length, byte count, phase enables and send vector are captured when a transaction is accepted, so they may change while it runs. Running totals of serial-clock and processor-clock pulses are kept. A typical transaction enables the processor pulse, the lone serial pulse and the scan, with the closing phase off.

Top module: `scan_txn_seq`

## Requirements
- R1: After reset `sclk`, `mosi`, `cpu_clk`, `busy` and `done` are 0, both pulse counts are 0 and `recv_vec` is 0.
- R2: Every high half and every low half between scan pulses of `sclk`, and every high half of `cpu_clk`, lasts exactly 2*`quarter_len` cycles, using the value captured at start.
- R3: The pre processor phase (`en_pre_cpu`=1) drives `cpu_clk` high for a half period, then low for a half period; `cpu_count` goes up by 1 in the cycle `cpu_clk` falls, and `cpu_count` changes at no other time.
- R4: The lone serial phase (`en_pre_spi`=1) gives one `sclk` high half followed by the next phase, with `mosi` held 0; `spi_count` goes up by 1 in the cycle `sclk` falls, for every `sclk` pulse of any phase.
- R5: The scan (`en_scan`=1, `nbytes`>0) gives 8*`nbytes` `sclk` pulses; bit 8*`nbytes`-1 of `send_vec` is on `mosi` a half period before the first rise, and after each fall `mosi` moves to the next lower bit, so the bits go out from highest to bit 0. `mosi` is stable while `sclk` is high and is 0 outside the scan.
- R6: `miso` is sampled in the cycle `sclk` rises; the first bit sampled lands at `recv_vec` bit 8*`nbytes`-1 and the last at bit 0; all higher bits are 0. `recv_vec` is cleared when a transaction is accepted.
- R7: The closing phase (`en_post`=1) pulses `cpu_clk` once (high half, low half) and then `sclk` once; both counts go up by 1.
- R8: Phases run in the order pre processor, lone serial, scan, closing. With H half periods in the enabled phases (2, 1, 1+16*`nbytes`, 3 respectively), `done` is a one-cycle pulse seen after 1+2*`quarter_len`*H clock edges from the edge that accepted start; with no phase enabled H is 0. `busy` is high from acceptance until `done`.
- R9: `start` while `busy` is ignored: the running transaction keeps its captured settings and gives one `done`.
- R10: With `quarter_len`=0 a `start` is ignored: `busy` stays 0, no `done`, counts unchanged.
- R11: With `nbytes`=0 the scan phase is skipped; `nbytes` above the buffer size is treated as the buffer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transaction request, taken when idle |
| en_pre_cpu | input | 1 | Enable pre processor clock pulse |
| en_pre_spi | input | 1 | Enable lone serial clock pulse |
| en_scan | input | 1 | Enable full scan |
| en_post | input | 1 | Enable closing processor then serial pulse |
| nbytes | input | $clog2(NB+1) | Bytes to scan |
| quarter_len | input | QW | Quarter period in clock cycles |
| send_vec | input | NB*8 | Vector to shift out, bit 8*nbytes-1 first |
| miso | input | 1 | Serial data from target |
| sclk | output | 1 | Serial clock to target |
| mosi | output | 1 | Serial data to target |
| cpu_clk | output | 1 | Target processor clock |
| recv_vec | output | NB*8 | Captured return vector |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_count | output | CW | Total serial clock pulses |
| cpu_count | output | CW | Total processor clock pulses |

## Verification
A wrong phase state or a bad half-period timer shows at once on the generated clocks: a pulse width other than twice the quarter length, a processor pulse in the wrong order against the serial pulses, or a `done` edge that misses the exact cycle predicted from the enabled phases. A slip in the bit counter or the shift path shows at the end of the scan as a pulse total off by one or as a send or return vector shifted by a bit, and a bad counter step shows in the cycle after the clock edge it should track.

// File: rtl/sq_pkg.sv
package sq_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_CPU_HI, S_CPU_LO, S_SPI_HI, S_LEAD, S_BIT_HI, S_BIT_LO,
      S_PCPU_HI, S_PCPU_LO, S_PSPI_HI, S_FIN
   } sq_state_e;

   // phase mask bits: 0 pre cpu, 1 lone sclk, 2 scan, 3 closing
   localparam int PH_PCPU = 0;
   localparam int PH_PSPI = 1;
   localparam int PH_SCAN = 2;
   localparam int PH_POST = 3;

   function automatic sq_state_e first_phase(input logic [3:0] m);
      if (m[PH_PCPU])      return S_CPU_HI;
      else if (m[PH_PSPI]) return S_SPI_HI;
      else if (m[PH_SCAN]) return S_LEAD;
      else if (m[PH_POST]) return S_PCPU_HI;
      else                 return S_FIN;
   endfunction

endpackage

// File: rtl/sq_qtimer.sv
module sq_qtimer #(
   parameter int QW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [QW-1:0] q_len,
   output logic          half_end
);
   logic [QW-1:0] qcnt;
   logic          second;
   logic          qtick;

   assign qtick    = run && (qcnt == q_len - 1'b1);
   assign half_end = qtick && second;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qcnt   <= '0;
         second <= 1'b0;
      end else if (!run) begin
         qcnt   <= '0;
         second <= 1'b0;
      end else if (qtick) begin
         qcnt   <= '0;
         second <= !second;
      end else begin
         qcnt   <= qcnt + 1'b1;
      end
   end
endmodule

// File: rtl/sq_shifter.sv
module sq_shifter #(
   parameter int NB = 8,
   localparam int VW = NB * 8,
   localparam int BW = $clog2(NB + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [BW-1:0] nb,
   input  logic [VW-1:0] send_vec,
   input  logic          shift_tx,
   input  logic          capture,
   input  logic          miso,
   output logic          tx_msb,
   output logic [VW-1:0] rx_vec
);
   logic [VW-1:0] tx;

   assign tx_msb = tx[VW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx     <= '0;
         rx_vec <= '0;
      end else if (load) begin
         tx     <= send_vec << (8 * (NB - int'(nb)));
         rx_vec <= '0;
      end else begin
         if (shift_tx) tx     <= {tx[VW-2:0], 1'b0};
         if (capture)  rx_vec <= {rx_vec[VW-2:0], miso};
      end
   end
endmodule

// File: rtl/sq_pulse_count.sv
module sq_pulse_count #(
   parameter int CW  = 32,
   parameter bit SAT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] count
);
   generate
      if (SAT) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  count <= '0;
            else if (inc && count != '1) count <= count + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   count <= '0;
            else if (inc) count <= count + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
   import sq_pkg::*;
#(
   parameter int NB = 8,
   parameter int QW = 16,
   localparam int BW  = $clog2(NB + 1),
   localparam int BLW = $clog2(NB * 8 + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    en,
   input  logic [BW-1:0] nbytes,
   input  logic [QW-1:0] quarter_len,
   input  logic          half_end,
   output sq_state_e     state,
   output logic [QW-1:0] q_lat,
   output logic [BW-1:0] nb_eff,
   output logic          accept,
   output logic          run,
   output logic          shift_tx,
   output logic          capture,
   output logic          spi_inc,
   output logic          cpu_inc
);
   logic [3:0]     mask, mask_in;
   logic [BLW-1:0] bits_left;

   assign nb_eff  = (nbytes > BW'(NB)) ? BW'(NB) : nbytes;
   assign mask_in = {en[PH_POST], en[PH_SCAN] && (nb_eff != '0), en[PH_PSPI], en[PH_PCPU]};
   assign accept  = (state == S_IDLE) && start && (quarter_len != '0);
   assign run     = (state != S_IDLE) && (state != S_FIN);

   assign shift_tx = half_end && (state == S_BIT_HI);
   assign capture  = half_end && ((state == S_LEAD) ||
                                  ((state == S_BIT_LO) && (bits_left != '0)));
   assign spi_inc  = half_end && ((state == S_SPI_HI) || (state == S_BIT_HI) ||
                                  (state == S_PSPI_HI));
   assign cpu_inc  = half_end && ((state == S_CPU_HI) || (state == S_PCPU_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         mask      <= '0;
         q_lat     <= '0;
         bits_left <= '0;
      end else if (accept) begin
         mask      <= mask_in;
         q_lat     <= quarter_len;
         bits_left <= BLW'({nb_eff, 3'b000});
         state     <= first_phase(mask_in);
      end else if (state == S_FIN) begin
         state     <= S_IDLE;
      end else if (half_end) begin
         unique case (state)
            S_CPU_HI:  state <= S_CPU_LO;
            S_CPU_LO:  state <= first_phase(mask & 4'b1110);
            S_SPI_HI:  state <= first_phase(mask & 4'b1100);
            S_LEAD:    state <= S_BIT_HI;
            S_BIT_HI: begin
               state     <= S_BIT_LO;
               bits_left <= bits_left - 1'b1;
            end
            S_BIT_LO:  state <= (bits_left == '0) ? first_phase(mask & 4'b1000) : S_BIT_HI;
            S_PCPU_HI: state <= S_PCPU_LO;
            S_PCPU_LO: state <= S_PSPI_HI;
            S_PSPI_HI: state <= S_FIN;
            default:   state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/scan_txn_seq.sv
module scan_txn_seq
   import sq_pkg::*;
#(
   parameter int NB        = 8,
   parameter int QW        = 16,
   parameter int CW        = 32,
   parameter bit COUNT_SAT = 1'b0,
   localparam int VW = NB * 8,
   localparam int BW = $clog2(NB + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          en_pre_cpu,
   input  logic          en_pre_spi,
   input  logic          en_scan,
   input  logic          en_post,
   input  logic [BW-1:0] nbytes,
   input  logic [QW-1:0] quarter_len,
   input  logic [VW-1:0] send_vec,
   input  logic          miso,
   output logic          sclk,
   output logic          mosi,
   output logic          cpu_clk,
   output logic [VW-1:0] recv_vec,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] spi_count,
   output logic [CW-1:0] cpu_count
);
   generate
      if (NB < 1) begin : g_bad_nb
         $error("NB must be at least 1");
      end
      if (QW < 1) begin : g_bad_qw
         $error("QW must be at least 1");
      end
      if (CW < 2) begin : g_bad_cw
         $error("CW must be at least 2");
      end
   endgenerate

   sq_state_e     state;
   logic [QW-1:0] q_lat;
   logic [BW-1:0] nb_eff;
   logic          accept, run, half_end, shift_tx, capture, spi_inc, cpu_inc, tx_msb;

   sq_ctrl #(.NB(NB), .QW(QW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .en({en_post, en_scan, en_pre_spi, en_pre_cpu}),
      .nbytes(nbytes), .quarter_len(quarter_len), .half_end(half_end),
      .state(state), .q_lat(q_lat), .nb_eff(nb_eff), .accept(accept), .run(run),
      .shift_tx(shift_tx), .capture(capture), .spi_inc(spi_inc), .cpu_inc(cpu_inc)
   );

   sq_qtimer #(.QW(QW)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .q_len(q_lat), .half_end(half_end)
   );

   sq_shifter #(.NB(NB)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept), .nb(nb_eff), .send_vec(send_vec),
      .shift_tx(shift_tx), .capture(capture), .miso(miso),
      .tx_msb(tx_msb), .rx_vec(recv_vec)
   );

   sq_pulse_count #(.CW(CW), .SAT(COUNT_SAT)) u_spi_cnt (
      .clk(clk), .rst_n(rst_n), .inc(spi_inc), .count(spi_count)
   );

   sq_pulse_count #(.CW(CW), .SAT(COUNT_SAT)) u_cpu_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cpu_inc), .count(cpu_count)
   );

   assign sclk    = (state == S_SPI_HI) || (state == S_BIT_HI) || (state == S_PSPI_HI);
   assign cpu_clk = (state == S_CPU_HI) || (state == S_PCPU_HI);
   assign mosi    = tx_msb && ((state == S_LEAD) || (state == S_BIT_HI) || (state == S_BIT_LO));
   assign busy    = run;
   assign done    = (state == S_FIN);
endmodule

// File: rtl/sq_chk.sv
module sq_chk #(
   parameter int QW = 16,
   parameter int CW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sclk,
   input logic          cpu_clk,
   input logic          mosi,
   input logic          busy,
   input logic          done,
   input logic [QW-1:0] quarter_len,
   input logic [CW-1:0] spi_count,
   input logic [CW-1:0] cpu_count
);
   // R2: the two generated clocks never overlap
   a_r2_clocks_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(sclk && cpu_clk));

   // R4: serial count steps with each serial clock fall
   a_r4_spi_count_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> spi_count == CW'($past(spi_count) + 1'b1));

   // R3: processor count steps with each processor clock fall
   a_r3_cpu_count_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_clk) |-> cpu_count == CW'($past(cpu_count) + 1'b1));

   // R3: processor count moves only on a processor clock fall
   a_r3_cpu_count_only_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_count != $past(cpu_count)) |-> $fell(cpu_clk));

   // R5: data held while the serial clock is high
   a_r5_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   // R8: completion is a single-cycle pulse outside the busy window
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: zero quarter length keeps the sequencer idle
   a_r10_zero_quarter_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && quarter_len == '0) |=> !busy);
endmodule

bind scan_txn_seq sq_chk #(.QW(QW), .CW(CW)) u_sq_chk (
   .clk(clk), .rst_n(rst_n), .sclk(sclk), .cpu_clk(cpu_clk), .mosi(mosi),
   .busy(busy), .done(done), .quarter_len(quarter_len),
   .spi_count(spi_count), .cpu_count(cpu_count)
);

// File: tb/tb_scan_txn_seq.sv
`timescale 1ns/1ps
module tb_scan_txn_seq;
   localparam int NB = 8;
   localparam int QW = 16;
   localparam int CW = 32;
   localparam int VW = NB * 8;
   localparam int BW = $clog2(NB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          en_pre_cpu = 1'b0, en_pre_spi = 1'b0, en_scan = 1'b0, en_post = 1'b0;
   logic [BW-1:0] nbytes = '0;
   logic [QW-1:0] quarter_len = '0;
   logic [VW-1:0] send_vec = '0;
   logic          miso = 1'b0;
   logic          sclk, mosi, cpu_clk, busy, done;
   logic [VW-1:0] recv_vec;
   logic [CW-1:0] spi_count, cpu_count;

   scan_txn_seq #(.NB(NB), .QW(QW), .CW(CW)) dut (.*);

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   longint edges = 0;
   always @(posedge clk) edges <= edges + 1;

   // monitor state
   int done_cnt = 0;
   longint done_edge = 0;
   int m_q = 1, m_skip = 0, m_nbits = 0;
   logic [VW-1:0] tgt_g = '0, cap = '0;
   int rise_idx = 0, hi_w = 0, lo_w = 0, c_hi_w = 0, width_err = 0, mosi_err = 0;
   int cpu_rises = 0;
   longint first_sclk_rise = -1, last_sclk_rise = -1, first_cpu_rise = -1, last_cpu_rise = -1;
   logic sclk_q = 1'b0, cpu_q = 1'b0;

   always @(negedge clk) begin
      if (done) begin done_cnt++; done_edge = edges; end
      if (sclk && !sclk_q) begin
         if (rise_idx > m_skip && rise_idx < m_skip + m_nbits && lo_w != 2 * m_q) width_err++;
         if (rise_idx < m_skip && mosi) mosi_err++;
         if (rise_idx >= m_skip && rise_idx < m_skip + m_nbits) begin
            int k;
            k = rise_idx - m_skip;
            cap[m_nbits - 1 - k] = mosi;
            miso = (k + 1 < m_nbits) ? tgt_g[m_nbits - 2 - k] : 1'b0;
         end
         if (first_sclk_rise < 0) first_sclk_rise = edges;
         last_sclk_rise = edges;
         rise_idx++;
         hi_w = 1;
      end else if (sclk) hi_w++;
      if (!sclk && sclk_q) begin
         if (hi_w != 2 * m_q) width_err++;
         lo_w = 1;
      end else if (!sclk) lo_w++;
      if (cpu_clk && !cpu_q) begin
         if (first_cpu_rise < 0) first_cpu_rise = edges;
         last_cpu_rise = edges;
         cpu_rises++;
         c_hi_w = 1;
      end else if (cpu_clk) c_hi_w++;
      if (!cpu_clk && cpu_q && c_hi_w != 2 * m_q) width_err++;
      sclk_q = sclk;
      cpu_q  = cpu_clk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [VW-1:0] act, input logic [VW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_txn(input bit pc, input bit ps, input bit sc, input bit po,
                          input int nb, input int q, input logic [VW-1:0] sv,
                          input logic [VW-1:0] tv, input bit disturb, input string tag);
      int n_eff, nbits, h, guard, d0;
      longint s;
      logic [CW-1:0] spi0, cpu0;
      logic [VW-1:0] mask;
      n_eff = (nb > NB) ? NB : nb;
      nbits = (sc && n_eff > 0) ? 8 * n_eff : 0;
      h = 2 * pc + ps + ((nbits > 0) ? 1 + 2 * nbits : 0) + 3 * po;
      mask = (nbits == VW) ? '1 : ((VW'(1) << nbits) - 1'b1);
      @(negedge clk);
      spi0 = spi_count; cpu0 = cpu_count; d0 = done_cnt;
      m_q = q; m_skip = ps; m_nbits = nbits; tgt_g = tv; cap = '0;
      rise_idx = 0; width_err = 0; mosi_err = 0; cpu_rises = 0;
      first_sclk_rise = -1; last_sclk_rise = -1; first_cpu_rise = -1; last_cpu_rise = -1;
      miso = (nbits > 0) ? tv[nbits - 1] : 1'b0;
      en_pre_cpu = pc; en_pre_spi = ps; en_scan = sc; en_post = po;
      nbytes = BW'(nb); quarter_len = QW'(q); send_vec = sv;
      start = 1'b1; s = edges;
      @(negedge clk);
      start = 1'b0;
      chk(recv_vec == '0, "R6", {tag, " receive cleared at start"}, recv_vec, '0);
      chk(busy == (h > 0), "R8", {tag, " busy after accept"}, VW'(busy), VW'(h > 0));
      guard = 0;
      while (done_cnt == d0 && guard < 20000) begin
         @(negedge clk);
         guard++;
         if (disturb && guard == 5) begin
            start = 1'b1; quarter_len = QW'(q + 3); nbytes = BW'(1);
            send_vec = ~sv; en_post = 1'b1;
         end
         if (disturb && guard == 6) start = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk(done_cnt == d0 + 1, "R8", {tag, " single done pulse"}, VW'(done_cnt - d0), VW'(1));
      chk(done_edge - s == 1 + longint'(h) * 2 * q, "R8", {tag, " done timing"},
          VW'(done_edge - s), VW'(1 + h * 2 * q));
      chk(spi_count - spi0 == CW'(ps + nbits + po), "R4", {tag, " serial pulse total"},
          VW'(spi_count - spi0), VW'(ps + nbits + po));
      chk(cpu_count - cpu0 == CW'(pc + po), "R3", {tag, " processor pulse total"},
          VW'(cpu_count - cpu0), VW'(pc + po));
      chk(cpu_rises == pc + po, "R7", {tag, " processor rises"}, VW'(cpu_rises), VW'(pc + po));
      chk(width_err == 0, "R2", {tag, " half period widths"}, VW'(width_err), '0);
      chk(mosi_err == 0, "R4", {tag, " mosi low on lone pulse"}, VW'(mosi_err), '0);
      chk(mosi == 1'b0 && !busy, "R5", {tag, " mosi low when idle"}, VW'(mosi), '0);
      if (nbits > 0) begin
         chk(cap == (sv & mask), "R5", {tag, " bits sent on mosi"}, cap, sv & mask);
         chk(recv_vec == (tv & mask), "R6", {tag, " bits captured"}, recv_vec, tv & mask);
      end
      if (po)
         chk(last_cpu_rise < last_sclk_rise, "R7", {tag, " closing cpu before sclk"},
             VW'(last_cpu_rise), VW'(last_sclk_rise));
      if (pc && (ps || nbits > 0))
         chk(first_cpu_rise < first_sclk_rise, "R8", {tag, " pre cpu first"},
             VW'(first_cpu_rise), VW'(first_sclk_rise));
   endtask

   task automatic t_reset();
      chk(!sclk && !mosi && !cpu_clk && !busy && !done, "R1", "reset outputs",
          VW'({sclk, mosi, cpu_clk, busy, done}), '0);
      chk(spi_count == '0 && cpu_count == '0, "R1", "reset counts",
          VW'({spi_count, cpu_count}), '0);
      chk(recv_vec == '0, "R1", "reset receive", recv_vec, '0);
   endtask

   task automatic t_zero_quarter();
      logic [CW-1:0] s0, c0;
      int d0;
      @(negedge clk);
      s0 = spi_count; c0 = cpu_count; d0 = done_cnt;
      quarter_len = '0; en_pre_cpu = 1'b1; en_scan = 1'b1; nbytes = BW'(2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      chk(!busy && done_cnt == d0, "R10", "zero quarter ignored",
          VW'({busy, 1'b0}), '0);
      chk(spi_count == s0 && cpu_count == c0, "R10", "zero quarter counts",
          VW'(spi_count - s0 + cpu_count - c0), '0);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R3 R4 R5 R6: typical transaction
      run_txn(1, 1, 1, 0, 3, 2, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_00D3_5A1C, 0, "typical");
      // R5 R6: full width scan, shortest quarter
      run_txn(0, 0, 1, 0, 8, 1, 64'hA5C3_1E7F_9B24_6D08, 64'h3C96_E10F_7254_8BAD, 0, "full");
      // R7: closing phase only
      run_txn(0, 0, 0, 1, 2, 3, 64'h0, 64'h0, 0, "closing");
      // R7 R8: every phase
      run_txn(1, 1, 1, 1, 1, 1, 64'h0000_0000_0000_0096, 64'h0000_0000_0000_0069, 0, "allph");
      // R8: no phase
      run_txn(0, 0, 0, 0, 2, 2, 64'h0, 64'h0, 0, "nophase");
      // R9: start while busy
      run_txn(1, 1, 1, 0, 2, 2, 64'h0000_0000_0000_BEEF, 64'h0000_0000_0000_4E71, 1, "busystart");
      // R11: zero bytes and oversize count
      run_txn(0, 0, 1, 0, 0, 2, 64'hFFFF, 64'hFFFF, 0, "zerobytes");
      run_txn(0, 1, 1, 0, 9, 1, 64'h8000_0000_0000_0001, 64'hF0E1_D2C3_B4A5_9687, 0, "oversize");
      // R10
      t_zero_quarter();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule